// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Unit

This block holds an array of lock semaphores shared by several CPU cores on one register bus. Every bus access carries the bus master code of the requesting core. A core takes a semaphore in one of two ways. It can write a lock request and then read the register back to see who owns it. It can also read a locking alias, which takes a free semaphore and returns the result in the same access. An unlock only takes effect when the writer names the current owner exactly. A keyed bulk-release command frees every semaphore held by one core.

Each of two interrupt banks has its own enable, status and clear registers. A core reaches the bank that its master code maps to. When a semaphore is freed, the status bit is set in every bank that has enabled that semaphore. The bank's interrupt line is raised while any enabled status bit is set.

The bus is a single-cycle request interface. Read data is registered and comes back one cycle after the request, with a valid strobe. Word addresses are: 0x00+n for semaphore n, 0x20+n for the locking alias of n, 0x40/0x41/0x42 for the requester's interrupt enable/clear/status, 0x60 for bulk release and 0x61 for the clear key.

Top module: `mc_semaphore_unit`

## Requirements
- R1: After a synchronous reset, every semaphore reads as 0 (unlocked, owner fields zero), both interrupt enable and status registers read 0, the clear key reads 0, `irq` is 0 and `rsp_valid` is 0.
- R2: A read of word n (0x00..0x1F) returns bit 31 = lock, bits [11:8] = owner core, bits [7:0] = owner process and zero elsewhere. The result appears on `rsp_rdata` with `rsp_valid` high one cycle after the request. The read changes nothing. A write raises no `rsp_valid`.
- R3: A write to word n with bit 31 = 1 and bits [11:8] equal to `req_master` locks a free semaphore, with owner core = `req_master` and owner process = bits [7:0]. The write is ignored if the semaphore is already held (owner fields unchanged) or if bits [11:8] differ from `req_master`.
- R4: A read of word 0x20+n locks a free semaphore n with owner core = `req_master` and process 0. It returns the register value after the attempt. If the semaphore is held, the read returns the current value and changes nothing. Writes to 0x20..0x3F are ignored.
- R5: A write to word n with bit 31 = 0 frees semaphore n only if it is locked and bits [11:8] equal both `req_master` and the owner core, and bits [7:0] equal the owner process. Otherwise nothing changes. A freed semaphore reads as 0.
- R6: Word 0x61 holds a 16-bit clear key in bits [15:0] that any master can write and read back.
- R7: A write to word 0x60 with bits [31:16] equal to the stored key frees every locked semaphore whose owner core equals bits [11:8], all in one cycle. With any other key it changes nothing.
- R8: Master codes 0x3 and 0x4 reach interrupt bank 0, and 0x1 and 0x8 reach bank 1. For any other code, the interrupt registers read 0 and writes to them are ignored.
- R9: A semaphore freed by R5 or R7 sets status bit n in each bank whose enable bit n is 1. Status is readable at 0x42. `irq[b]` is the OR of bank b's status bits ANDed with its enable bits.
- R10: Writing 1s to word 0x41 clears the matching status bits of the requester's bank and leaves the other bits alone. The word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| req_master | input | 4 | Bus master code of the requester |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 2 | Per-bank interrupt lines |

## Verification
The bench targets the following corner cases:
- A lock request on a semaphore held by another core. A design that overwrote the owner would let two cores believe they hold the same lock.
- An unlock that names the right core but the wrong process, and a write whose core field does not match the bus master. A loose ownership check would free the lock or take it for the wrong core.
- A locking-alias read of a held semaphore. A design that locked again would report success to the second core.
- A bulk release with a wrong key, and one that must spare semaphores owned by other cores. These show up as missing or unwanted interrupt status bits.
- An unmapped master touching the interrupt registers, and a partial clear. These catch bank misrouting and clears that wipe too many bits.

// File: rtl/sema_pkg.sv
package sema_pkg;

    localparam int CORE_W    = 4;
    localparam int PROC_W    = 8;
    localparam int KEY_W     = 16;
    localparam int NUM_BANKS = 2;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] ADDR_IER  = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_ICR  = 8'h41;
    localparam logic [ADDR_W-1:0] ADDR_ISR  = 8'h42;
    localparam logic [ADDR_W-1:0] ADDR_BULK = 8'h60;
    localparam logic [ADDR_W-1:0] ADDR_KEY  = 8'h61;

    typedef struct packed {
        logic              locked;
        logic [CORE_W-1:0] core;
        logic [PROC_W-1:0] proc;
    } sem_state_t;

    typedef enum logic [1:0] {
        SOP_NONE   = 2'd0,
        SOP_LOCK2  = 2'd1,
        SOP_LOCK1  = 2'd2,
        SOP_UNLOCK = 2'd3
    } slot_op_e;

    function automatic logic [DATA_W-1:0] pack_sem(input sem_state_t s);
        return {s.locked, {(DATA_W-1-CORE_W-PROC_W){1'b0}}, s.core, s.proc};
    endfunction

    function automatic logic bank_hit(input logic [CORE_W-1:0] m);
        return (m == 4'h3) || (m == 4'h4) || (m == 4'h1) || (m == 4'h8);
    endfunction

    function automatic int unsigned bank_sel(input logic [CORE_W-1:0] m);
        return ((m == 4'h1) || (m == 4'h8)) ? 1 : 0;
    endfunction

endpackage

// File: rtl/sema_slot.sv
module sema_slot
    import sema_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_op_e          op,
    input  logic [CORE_W-1:0] req_core,
    input  logic [PROC_W-1:0] req_proc,
    input  logic              bulk_req,
    input  logic [CORE_W-1:0] bulk_core,
    output sem_state_t        cur,
    output logic              freed
);
    sem_state_t nxt;

    always_comb begin
        nxt   = cur;
        freed = 1'b0;
        case (op)
            SOP_LOCK2, SOP_LOCK1: begin
                if (!cur.locked) begin
                    nxt.locked = 1'b1;
                    nxt.core   = req_core;
                    nxt.proc   = (op == SOP_LOCK1) ? '0 : req_proc;
                end
            end
            SOP_UNLOCK: begin
                if (cur.locked && cur.core == req_core && cur.proc == req_proc) begin
                    nxt   = '0;
                    freed = 1'b1;
                end
            end
            default: ;
        endcase
        if (bulk_req && cur.locked && cur.core == bulk_core) begin
            nxt   = '0;
            freed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assert_held_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_LOCK2 && cur.locked && !bulk_req) |=> $stable(cur));

    assert_onestep_take_R4: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_LOCK1 && !cur.locked) |=> (cur.locked && cur.proc == '0));

    assert_owner_guard_R5: assert property (@(posedge clk) disable iff (rst)
        (op == SOP_UNLOCK && cur.locked && !bulk_req &&
         (cur.core != req_core || cur.proc != req_proc)) |=> cur.locked);

    assert_freed_clears_R9: assert property (@(posedge clk) disable iff (rst)
        freed |=> !cur.locked);

endmodule

// File: rtl/sema_irq_bank.sv
module sema_irq_bank
    import sema_pkg::*;
#(
    parameter int NUM_SEM = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_we,
    input  logic               clr_we,
    input  logic [NUM_SEM-1:0] wvec,
    input  logic [NUM_SEM-1:0] freed,
    output logic [NUM_SEM-1:0] enable,
    output logic [NUM_SEM-1:0] status,
    output logic               irq
);
    logic [NUM_SEM-1:0] clr_mask;

    assign clr_mask = clr_we ? wvec : '0;
    assign irq      = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            status <= '0;
        end else begin
            if (en_we) enable <= wvec;
            status <= (status & ~clr_mask) | (freed & enable);
        end
    end

    assert_freed_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (|(freed & enable)) |=> (|status));

    assert_clear_bits_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !(|freed)) |=> ((status & $past(wvec)) == '0));

endmodule

// File: rtl/mc_semaphore_unit.sv
module mc_semaphore_unit
    import sema_pkg::*;
#(
    parameter int NUM_SEM = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_master,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [1:0]        irq
);
    localparam int IDX_W = 5;

    logic                       wr, rd;
    logic [2:0]                 region;
    logic [IDX_W-1:0]           idx;
    logic [CORE_W-1:0]          wcore;
    logic [KEY_W-1:0]           key_q;
    logic                       bulk_req;
    logic                       own_hit;
    int unsigned                own_bank;
    sem_state_t [NUM_SEM-1:0]   sem_q;
    logic [NUM_SEM-1:0]         freed;
    logic [NUM_SEM-1:0]         en_q  [NUM_BANKS];
    logic [NUM_SEM-1:0]         sts_q [NUM_BANKS];
    logic [31:0]                rd_c;

    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;
    assign region   = req_addr[7:5];
    assign idx      = req_addr[IDX_W-1:0];
    assign wcore    = req_wdata[11:8];
    assign own_hit  = bank_hit(req_master);
    assign own_bank = bank_sel(req_master);
    assign bulk_req = wr && req_addr == ADDR_BULK && req_wdata[31:16] == key_q;

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_slot
        slot_op_e op_i;
        always_comb begin
            op_i = SOP_NONE;
            if (region == 3'd0 && wr && idx == IDX_W'(i) && wcore == req_master)
                op_i = req_wdata[31] ? SOP_LOCK2 : SOP_UNLOCK;
            else if (region == 3'd1 && rd && idx == IDX_W'(i))
                op_i = SOP_LOCK1;
        end
        sema_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .op        (op_i),
            .req_core  (req_master),
            .req_proc  (req_wdata[PROC_W-1:0]),
            .bulk_req  (bulk_req),
            .bulk_core (wcore),
            .cur       (sem_q[i]),
            .freed     (freed[i])
        );
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_b;
        assign sel_b = own_hit && own_bank == b;
        sema_irq_bank #(.NUM_SEM(NUM_SEM)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .en_we  (wr && sel_b && req_addr == ADDR_IER),
            .clr_we (wr && sel_b && req_addr == ADDR_ICR),
            .wvec   (req_wdata[NUM_SEM-1:0]),
            .freed  (freed),
            .enable (en_q[b]),
            .status (sts_q[b]),
            .irq    (irq[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                          key_q <= '0;
        else if (wr && req_addr == ADDR_KEY) key_q <= req_wdata[KEY_W-1:0];
    end

    always_comb begin
        rd_c = '0;
        for (int i = 0; i < NUM_SEM; i++) begin
            if (idx == IDX_W'(i)) begin
                if (region == 3'd0)
                    rd_c = pack_sem(sem_q[i]);
                else if (region == 3'd1)
                    rd_c = sem_q[i].locked ? pack_sem(sem_q[i])
                                           : {1'b1, 19'b0, req_master, 8'h00};
            end
        end
        if (req_addr == ADDR_IER && own_hit) rd_c = 32'(en_q[own_bank]);
        if (req_addr == ADDR_ISR && own_hit) rd_c = 32'(sts_q[own_bank]);
        if (req_addr == ADDR_KEY)            rd_c = 32'(key_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd;
            rsp_rdata <= rd ? rd_c : '0;
        end
    end

    assert_badkey_inert_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && req_addr == ADDR_BULK && req_wdata[31:16] != key_q) |=> $stable(sem_q));

    assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (rst)
        rd |=> rsp_valid);

endmodule

// File: tb/mc_semaphore_unit_tb_top.sv
`timescale 1ns/1ps
module mc_semaphore_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_master;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    bit          m_lk   [32];
    logic [3:0]  m_core [32];
    logic [7:0]  m_proc [32];
    logic [31:0] m_en   [2];
    logic [31:0] m_st   [2];
    logic [15:0] m_key;

    always #2.5 clk = ~clk;

    mc_semaphore_unit #(.NUM_SEM(32)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_master(req_master),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    function automatic int bank_of(input logic [3:0] m);
        if (m == 4'h3 || m == 4'h4) return 0;
        if (m == 4'h1 || m == 4'h8) return 1;
        return -1;
    endfunction

    function automatic logic [31:0] pk(input int i);
        return {m_lk[i], 19'b0, m_core[i], m_proc[i]};
    endfunction

    function automatic void free_sem(input int i);
        m_lk[i] = 0; m_core[i] = 0; m_proc[i] = 0;
        for (int b = 0; b < 2; b++) if (m_en[b][i]) m_st[b][i] = 1'b1;
    endfunction

    function automatic logic [31:0] model(input bit we, input logic [7:0] a,
                                          input logic [31:0] wd, input logic [3:0] m);
        int b = bank_of(m);
        logic [31:0] r = 0;
        if (a < 8'h20) begin
            int i = int'(a);
            if (!we) r = pk(i);
            else if (wd[11:8] == m) begin
                if (wd[31]) begin
                    if (!m_lk[i]) begin m_lk[i] = 1; m_core[i] = m; m_proc[i] = wd[7:0]; end
                end else if (m_lk[i] && m_core[i] == m && m_proc[i] == wd[7:0]) begin
                    free_sem(i);
                end
            end
        end else if (a < 8'h40) begin
            int i = int'(a) - 32;
            if (!we) begin
                if (!m_lk[i]) begin m_lk[i] = 1; m_core[i] = m; m_proc[i] = 0; end
                r = pk(i);
            end
        end else if (a == 8'h40) begin
            if (b >= 0) begin if (we) m_en[b] = wd; else r = m_en[b]; end
        end else if (a == 8'h41) begin
            if (b >= 0 && we) m_st[b] = m_st[b] & ~wd;
        end else if (a == 8'h42) begin
            if (b >= 0 && !we) r = m_st[b];
        end else if (a == 8'h60) begin
            if (we && wd[31:16] == m_key)
                for (int i = 0; i < 32; i++)
                    if (m_lk[i] && m_core[i] == wd[11:8]) free_sem(i);
        end else if (a == 8'h61) begin
            if (we) m_key = wd[15:0]; else r = {16'h0, m_key};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input bit we, input logic [7:0] a, input logic [31:0] wd,
                      input logic [3:0] m, input string tag);
        logic [31:0] exp;
        logic [1:0]  exp_irq;
        req_valid = 1; req_write = we; req_addr = a; req_wdata = wd; req_master = m;
        exp = model(we, a, wd, m);
        for (int b = 0; b < 2; b++) exp_irq[b] = |(m_en[b] & m_st[b]);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check(rsp_valid == !we, {tag, " R2 rsp_valid"}, 32'(rsp_valid), 32'(!we));
        if (!we) check(rsp_rdata == exp, tag, rsp_rdata, exp);
        check(irq == exp_irq, {tag, " R9 irq"}, 32'(irq), 32'(exp_irq));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_lk[i] = 0; m_core[i] = 0; m_proc[i] = 0; end
        m_en[0] = 0; m_en[1] = 0; m_st[0] = 0; m_st[1] = 0; m_key = 0;
        rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_master = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        check(rsp_valid == 0 && irq == 0, "R1 outputs", {30'b0, irq}, 0);
        // R1 reset state
        op(0, 8'h00, 0, 4'h3, "R1 sem0");
        op(0, 8'h1F, 0, 4'h3, "R1 sem31");
        op(0, 8'h40, 0, 4'h3, "R1 ier0");
        op(0, 8'h42, 0, 4'h1, "R1 isr1");
        op(0, 8'h61, 0, 4'h3, "R1 key");
        // R3 two-step lock
        op(1, 8'h05, 32'h8000_0305, 4'h3, "R3 lock");
        op(0, 8'h05, 0, 4'h3, "R3 readback");
        op(1, 8'h05, 32'h8000_0109, 4'h1, "R3 held");
        op(0, 8'h05, 0, 4'h1, "R3 owner kept");
        op(1, 8'h06, 32'h8000_0407, 4'h3, "R3 core mismatch");
        op(0, 8'h06, 0, 4'h3, "R3 still free");
        // R8 and R9 enables
        op(1, 8'h40, 32'h0000_00E0, 4'h4, "R8 ier bank0");
        op(1, 8'h40, 32'h0000_0020, 4'h8, "R8 ier bank1");
        op(0, 8'h40, 0, 4'h3, "R8 bank0 via 3");
        op(0, 8'h40, 0, 4'h1, "R8 bank1 via 1");
        op(1, 8'h40, 32'hFFFF_FFFF, 4'h2, "R8 unmapped write");
        op(0, 8'h40, 0, 4'h2, "R8 unmapped read");
        op(0, 8'h40, 0, 4'h4, "R8 bank0 unchanged");
        // R5 unlock
        op(1, 8'h05, 32'h0000_0306, 4'h3, "R5 wrong proc");
        op(0, 8'h05, 0, 4'h3, "R5 still held");
        op(1, 8'h05, 32'h0000_0105, 4'h1, "R5 wrong core");
        op(1, 8'h05, 32'h0000_0305, 4'h3, "R5 good unlock");
        op(0, 8'h05, 0, 4'h3, "R5 freed");
        op(0, 8'h42, 0, 4'h3, "R9 status bank0");
        op(0, 8'h42, 0, 4'h8, "R9 status bank1");
        op(1, 8'h05, 32'h0000_0305, 4'h3, "R5 unlock free");
        // R4 one-step
        op(0, 8'h27, 0, 4'h4, "R4 take");
        op(0, 8'h27, 0, 4'h1, "R4 held");
        op(0, 8'h07, 0, 4'h1, "R4 owner kept");
        op(1, 8'h28, 32'hFFFF_FFFF, 4'h4, "R4 alias write");
        op(0, 8'h08, 0, 4'h4, "R4 alias write inert");
        op(0, 8'h26, 0, 4'h4, "R4 take 6");
        op(0, 8'h29, 0, 4'h1, "R4 take 9 by 1");
        // R6 key and R7 bulk
        op(1, 8'h61, 32'hABCD_1234, 4'h8, "R6 key write");
        op(0, 8'h61, 0, 4'h3, "R6 key read");
        op(1, 8'h60, 32'h1235_0400, 4'h4, "R7 bad key");
        op(0, 8'h07, 0, 4'h4, "R7 bad key held");
        op(1, 8'h60, 32'h1234_0400, 4'h3, "R7 good key");
        op(0, 8'h06, 0, 4'h4, "R7 freed 6");
        op(0, 8'h07, 0, 4'h4, "R7 freed 7");
        op(0, 8'h09, 0, 4'h1, "R7 other core kept");
        op(0, 8'h42, 0, 4'h3, "R9 bulk status");
        // R10 clear
        op(1, 8'h42 - 8'h01, 32'h0000_0040, 4'h4, "R10 clear bit6");
        op(0, 8'h42, 0, 4'h3, "R10 partial");
        op(0, 8'h41, 0, 4'h3, "R10 reads zero");
        op(1, 8'h41, 32'hFFFF_FFFF, 4'h3, "R10 clear all");
        op(1, 8'h41, 32'hFFFF_FFFF, 4'h1, "R10 clear bank1");
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [3:0]  mm;
            logic [7:0]  aa;
            logic [31:0] dd;
            int k = $urandom_range(0, 9);
            int s = $urandom_range(0, 7);
            case ($urandom_range(0, 4))
                0: mm = 4'h1; 1: mm = 4'h3; 2: mm = 4'h4; 3: mm = 4'h8; default: mm = 4'h2;
            endcase
            dd = {$urandom_range(0, 1) ? 1'b1 : 1'b0, 19'b0,
                  ($urandom_range(0, 5) == 0) ? 4'h3 : mm, 5'b0, 3'($urandom_range(0, 3))};
            case (k)
                0, 1, 2: aa = 8'(s);
                3, 4:    aa = 8'h20 + 8'(s);
                5:       begin aa = 8'h40; dd = $urandom; end
                6:       begin aa = 8'h41; dd = $urandom; end
                7:       aa = 8'h42;
                8:       begin aa = 8'h60; dd = {($urandom_range(0, 3) == 0) ? 16'h5555 : m_key, 4'h0, mm, 8'h0}; end
                default: begin aa = 8'h61; dd = $urandom; end
            endcase
            op(($urandom_range(0, 1) == 1), aa, dd, mm, "R9 random mix");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule